// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

This block sits between a narrow requester that moves 16 bits at a time and a bank of 32-bit registers. A 32-bit register must never see half of a new value. So a write of the lower half is only parked in a holding register. The single 32-bit write toward the registers goes out when the upper half arrives.

Reads work the same way in the other direction. A read of the lower half performs the full 32-bit register read and returns the low 16 bits. The upper 16 bits of that same read are kept. A later read of the upper half is then served from that saved copy, so both halves come from one instant. The requester must access the lower half first in both directions.

Full-word requests go through to the register side unchanged. Byte-wide requests and malformed requests are refused with an error pulse and have no effect. The bridge issues every register-side access one cycle after the request and returns read data in that same cycle.

Top module: `hw2w_bridge`

## Requirements
- R1: After reset, and in every cycle that reset is held, both holding registers are zero and every output strobe (`m_wr`, `m_rd`, `s_rvalid`, `s_err`) is low. An upper-half read issued straight after reset returns 0. An upper-half write issued straight after reset sends 0 in bits 15:0.
- R2: A half-word write (`s_size` = 2'b01) with `s_addr[1]` = 0 stores `s_wdata[15:0]` in the low holding register. It drives no register-side strobe.
- R3: A half-word write with `s_addr[1]` = 1 drives `m_wr` high for exactly one cycle, in the cycle after the request. `m_wdata` = {`s_wdata[15:0]`, low holding register}.
- R4: A half-word read with `s_addr[1]` = 0 drives `m_rd` for one cycle in the cycle after the request. In that cycle `s_rvalid` = 1 and `s_rdata` = {16'h0, `m_rdata[15:0]`}, and `m_rdata[31:16]` is stored in the high holding register.
- R5: A half-word read with `s_addr[1]` = 1 drives no register-side strobe. In the next cycle `s_rvalid` = 1 and `s_rdata` = {16'h0, high holding register}.
- R6: A word request (`s_size` = 2'b10) drives `m_wr` (with `m_wdata` = `s_wdata`) or `m_rd` for one cycle in the next cycle. A word read returns `m_rdata` unchanged with `s_rvalid` = 1.
- R7: The following requests raise `s_err` for one cycle in the next cycle: a byte request (`s_size` = 2'b00), the reserved size 2'b11, or `s_wr` and `s_rd` together. Such a request drives no strobe, gives no `s_rvalid`, and leaves both holding registers unchanged.
- R8: `m_wr` and `m_rd` are never high together, and no strobe appears in a cycle that follows no accepted request.
- R9: Whenever a strobe is high, `m_addr` equals the request address with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | AW (12) | Requester byte address |
| s_wr | input | 1 | Requester write, one cycle per request |
| s_rd | input | 1 | Requester read, one cycle per request |
| s_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| s_wdata | input | DW (32) | Write data; half-word writes use bits 15:0 |
| s_rdata | output | DW (32) | Read data, valid with s_rvalid |
| s_rvalid | output | 1 | Read response, cycle after the request |
| s_err | output | 1 | Request refused, cycle after the request |
| m_addr | output | AW (12) | Word-aligned register address |
| m_wr | output | 1 | Register write strobe |
| m_rd | output | 1 | Register read strobe |
| m_wdata | output | DW (32) | Register write data |
| m_rdata | input | DW (32) | Register read data, same cycle as m_rd |

## Verification
The assertions rely on two assumptions. First, the register side answers combinationally in the same cycle as `m_rd`. Second, each requester strobe stands for one request in its own cycle, so the checks can tie one request to the strobe in the following cycle. The bench's register model is a small array read combinationally from `m_addr`. The bench changes inputs only on falling edges and issues at most one request per cycle, including back-to-back lower/upper pairs. It also sends deliberately conflicting or byte-wide requests to exercise the refusal path rather than to break the cycle assumptions.

// File: rtl/hw2w_pkg.sv
package hw2w_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LO_WR,
        OP_HI_WR,
        OP_LO_RD,
        OP_HI_RD,
        OP_W_WR,
        OP_W_RD,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic valid;
        op_e  op;
    } rsp_t;

    function automatic logic op_writes_reg(op_e op);
        return (op == OP_HI_WR) || (op == OP_W_WR);
    endfunction

    function automatic logic op_reads_reg(op_e op);
        return (op == OP_LO_RD) || (op == OP_W_RD);
    endfunction

    function automatic logic op_answers(op_e op);
        return (op == OP_LO_RD) || (op == OP_HI_RD) || (op == OP_W_RD);
    endfunction

endpackage

// File: rtl/hw2w_decode.sv
module hw2w_decode
    import hw2w_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    size,
    output op_e           op
);
    size_e sz;
    assign sz = size_e'(size);

    always_comb begin
        op = OP_NONE;
        if (wr && rd) begin
            op = OP_BAD;
        end else if (wr || rd) begin
            unique case (sz)
                SZ_HALF: begin
                    if (wr) op = addr[1] ? OP_HI_WR : OP_LO_WR;
                    else    op = addr[1] ? OP_HI_RD : OP_LO_RD;
                end
                SZ_WORD: op = wr ? OP_W_WR : OP_W_RD;
                default: op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/hw2w_hold.sv
module hw2w_hold
    import hw2w_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [HW-1:0] lo_in,
    input  logic          cap_hi,
    input  logic [HW-1:0] hi_in,
    output logic [HW-1:0] hold_lo,
    output logic [HW-1:0] hold_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_lo <= '0;
            hold_hi <= '0;
        end else begin
            if (op == OP_LO_WR) hold_lo <= lo_in;
            if (cap_hi)         hold_hi <= hi_in;
        end
    end

    // R1: holding registers cleared by reset
    a_r1_hold_clear: assert property (@(posedge clk)
        rst |=> (hold_lo == '0) && (hold_hi == '0));

    // R7: a refused request leaves the low holding register alone
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BAD) |=> $stable(hold_lo));
endmodule

// File: rtl/hw2w_issue.sv
module hw2w_issue
    import hw2w_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW/2-1:0] hold_lo,
    output logic [AW-1:0] m_addr,
    output logic          m_wr,
    output logic          m_rd,
    output logic [DW-1:0] m_wdata,
    output rsp_t          rsp,
    output logic          err
);
    localparam int HW = DW / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_addr  <= '0;
            m_wr    <= 1'b0;
            m_rd    <= 1'b0;
            m_wdata <= '0;
            rsp     <= '{valid: 1'b0, op: OP_NONE};
            err     <= 1'b0;
        end else begin
            m_addr  <= {addr[AW-1:2], 2'b00};
            m_wr    <= op_writes_reg(op);
            m_rd    <= op_reads_reg(op);
            m_wdata <= (op == OP_HI_WR) ? {wdata[HW-1:0], hold_lo} : wdata;
            rsp     <= '{valid: op_answers(op), op: op};
            err     <= (op == OP_BAD);
        end
    end

    // R8: never both strobes
    a_r8_excl: assert property (@(posedge clk) disable iff (rst)
        !(m_wr && m_rd));

    // R9: strobed address is word aligned
    a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
        (m_wr || m_rd) |-> (m_addr[1:0] == 2'b00));
endmodule

// File: rtl/hw2w_bridge.sv
module hw2w_bridge
    import hw2w_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] s_addr,
    input  logic          s_wr,
    input  logic          s_rd,
    input  logic [1:0]    s_size,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          s_rvalid,
    output logic          s_err,
    output logic [AW-1:0] m_addr,
    output logic          m_wr,
    output logic          m_rd,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata
);
    localparam int HW = DW / 2;

    op_e           op;
    rsp_t          rsp;
    logic [HW-1:0] hold_lo;
    logic [HW-1:0] hold_hi;
    logic          cap_hi;

    hw2w_decode #(.AW(AW)) u_dec (
        .addr (s_addr),
        .wr   (s_wr),
        .rd   (s_rd),
        .size (s_size),
        .op   (op)
    );

    hw2w_issue #(.AW(AW), .DW(DW)) u_iss (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .addr    (s_addr),
        .wdata   (s_wdata),
        .hold_lo (hold_lo),
        .m_addr  (m_addr),
        .m_wr    (m_wr),
        .m_rd    (m_rd),
        .m_wdata (m_wdata),
        .rsp     (rsp),
        .err     (s_err)
    );

    assign cap_hi = rsp.valid && (rsp.op == OP_LO_RD);

    hw2w_hold #(.HW(HW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .lo_in   (s_wdata[HW-1:0]),
        .cap_hi  (cap_hi),
        .hi_in   (m_rdata[DW-1:HW]),
        .hold_lo (hold_lo),
        .hold_hi (hold_hi)
    );

    always_comb begin
        s_rvalid = rsp.valid;
        s_rdata  = '0;
        if (rsp.valid) begin
            unique case (rsp.op)
                OP_LO_RD: s_rdata = {{HW{1'b0}}, m_rdata[HW-1:0]};
                OP_HI_RD: s_rdata = {{HW{1'b0}}, hold_hi};
                default:  s_rdata = m_rdata;
            endcase
        end
    end

    // R2: lower-half write reaches no register
    a_r2_lo_quiet: assert property (@(posedge clk) disable iff (rst)
        (s_wr && !s_rd && s_size == 2'b01 && !s_addr[1]) |=> (!m_wr && !m_rd));

    // R3: upper-half write commits held low half
    a_r3_commit: assert property (@(posedge clk) disable iff (rst)
        (s_wr && !s_rd && s_size == 2'b01 && s_addr[1])
            |=> (m_wr && m_wdata[HW-1:0] == $past(hold_lo)));

    // R5: upper-half read answered without register access
    a_r5_hi_local: assert property (@(posedge clk) disable iff (rst)
        (s_rd && !s_wr && s_size == 2'b01 && s_addr[1])
            |=> (s_rvalid && !m_rd && !m_wr));

    // R7: refused request is silent on the register side
    a_r7_refuse: assert property (@(posedge clk) disable iff (rst)
        s_err |-> (!m_wr && !m_rd && !s_rvalid));

    // R8: no strobe without a request one cycle earlier
    a_r8_cause: assert property (@(posedge clk) disable iff (rst)
        !(s_wr || s_rd) |=> (!m_wr && !m_rd && !s_err));
endmodule

// File: tb/sim_hw2w_bridge.sv
`timescale 1ns/1ps
module sim_hw2w_bridge;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] s_addr = '0;
    logic          s_wr = 1'b0;
    logic          s_rd = 1'b0;
    logic [1:0]    s_size = 2'b00;
    logic [DW-1:0] s_wdata = '0;
    logic [DW-1:0] s_rdata;
    logic          s_rvalid;
    logic          s_err;
    logic [AW-1:0] m_addr;
    logic          m_wr;
    logic          m_rd;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_rdata;

    logic [DW-1:0] regs [16];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    hw2w_bridge #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd),
        .s_size(s_size), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_rvalid(s_rvalid), .s_err(s_err), .m_addr(m_addr), .m_wr(m_wr),
        .m_rd(m_rd), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    assign m_rdata = regs[m_addr[5:2]];
    always @(posedge clk) if (m_wr) regs[m_addr[5:2]] <= m_wdata;

    typedef struct packed {
        logic [1:0]  size;
        logic        wr;
        logic        rd;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        ewr;
        logic        erd;
        logic [11:0] eaddr;
        logic [31:0] ewdata;
        logic        erv;
        logic [31:0] erdata;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R6 word write
        '{2'b10,1'b1,1'b0,12'h010,32'h11223344, 1'b1,1'b0,12'h010,32'h11223344, 1'b0,32'h0,1'b0,4'd6},
        // R6 word read
        '{2'b10,1'b0,1'b1,12'h010,32'h0, 1'b0,1'b1,12'h010,32'h0, 1'b1,32'h11223344,1'b0,4'd6},
        // R4 lower-half read
        '{2'b01,1'b0,1'b1,12'h010,32'h0, 1'b0,1'b1,12'h010,32'h0, 1'b1,32'h00003344,1'b0,4'd4},
        // R5 upper-half read from snapshot
        '{2'b01,1'b0,1'b1,12'h012,32'h0, 1'b0,1'b0,12'h000,32'h0, 1'b1,32'h00001122,1'b0,4'd5},
        // R2 lower-half write parks only
        '{2'b01,1'b1,1'b0,12'h020,32'h0000BEEF, 1'b0,1'b0,12'h000,32'h0, 1'b0,32'h0,1'b0,4'd2},
        // R3 upper-half write commits
        '{2'b01,1'b1,1'b0,12'h022,32'h0000DEAD, 1'b1,1'b0,12'h020,32'hDEADBEEF, 1'b0,32'h0,1'b0,4'd3},
        // R3 committed word visible
        '{2'b10,1'b0,1'b1,12'h020,32'h0, 1'b0,1'b1,12'h020,32'h0, 1'b1,32'hDEADBEEF,1'b0,4'd3},
        // R7 byte write refused
        '{2'b00,1'b1,1'b0,12'h020,32'h000000FF, 1'b0,1'b0,12'h000,32'h0, 1'b0,32'h0,1'b1,4'd7},
        // R9 unaligned word read goes to aligned address
        '{2'b10,1'b0,1'b1,12'h023,32'h0, 1'b0,1'b1,12'h020,32'h0, 1'b1,32'hDEADBEEF,1'b0,4'd9},
        // R7 byte write did not touch held low half
        '{2'b01,1'b1,1'b0,12'h032,32'h00005555, 1'b1,1'b0,12'h030,32'h5555BEEF, 1'b0,32'h0,1'b0,4'd7},
        // R4 lower-half read after commit
        '{2'b01,1'b0,1'b1,12'h030,32'h0, 1'b0,1'b1,12'h030,32'h0, 1'b1,32'h0000BEEF,1'b0,4'd4},
        // R6 word write over the register
        '{2'b10,1'b1,1'b0,12'h030,32'h00000000, 1'b1,1'b0,12'h030,32'h00000000, 1'b0,32'h0,1'b0,4'd6},
        // R5 snapshot survives a later word write
        '{2'b01,1'b0,1'b1,12'h032,32'h0, 1'b0,1'b0,12'h000,32'h0, 1'b1,32'h00005555,1'b0,4'd5},
        // R7 reserved size refused
        '{2'b11,1'b0,1'b1,12'h030,32'h0, 1'b0,1'b0,12'h000,32'h0, 1'b0,32'h0,1'b1,4'd7}
    };

    task automatic drive(input logic [1:0] sz, input logic wr, input logic rd,
                         input logic [11:0] a, input logic [31:0] d);
        s_size = sz; s_wr = wr; s_rd = rd; s_addr = a; s_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        s_wr = 1'b0; s_rd = 1'b0; s_size = 2'b00; s_addr = '0; s_wdata = '0;
    endtask

    task automatic expect_out(input int req, input logic ewr, input logic erd,
                              input logic [11:0] eaddr, input logic [31:0] ewdata,
                              input logic erv, input logic [31:0] erdata,
                              input logic eerr);
        logic ok;
        ok = (m_wr === ewr) && (m_rd === erd) && (s_rvalid === erv) && (s_err === eerr);
        if ((ewr || erd) && m_addr !== eaddr) ok = 1'b0;
        if (ewr && m_wdata !== ewdata) ok = 1'b0;
        if (erv && s_rdata !== erdata) ok = 1'b0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual wr=%b rd=%b addr=%h wdata=%h rv=%b rdata=%h err=%b expected wr=%b rd=%b addr=%h wdata=%h rv=%b rdata=%h err=%b",
                     req, m_wr, m_rd, m_addr, m_wdata, s_rvalid, s_rdata, s_err,
                     ewr, erd, eaddr, ewdata, erv, erdata, eerr);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R8: watchdog expired, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        // R1: outputs quiet while reset is held, even with a request present
        s_wr = 1'b1; s_size = 2'b10; s_addr = 12'h010; s_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        expect_out(1, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b0);
        idle();
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].size, VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wdata);
            expect_out(int'(VEC[i].req), VEC[i].ewr, VEC[i].erd, VEC[i].eaddr,
                       VEC[i].ewdata, VEC[i].erv, VEC[i].erdata, VEC[i].eerr);
        end

        // R7: write and read together refused
        drive(2'b10, 1'b1, 1'b1, 12'h010, 32'h0);
        expect_out(7, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b1);

        // R8: idle cycle carries no strobe
        idle();
        @(negedge clk);
        expect_out(8, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b0);

        // R1: reset clears both holding registers
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(2'b01, 1'b0, 1'b1, 12'h012, 32'h0);
        expect_out(1, 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 32'h0, 1'b0);
        drive(2'b01, 1'b1, 1'b0, 12'h042, 32'h00001234);
        expect_out(1, 1'b1, 1'b0, 12'h040, 32'h12340000, 1'b0, 32'h0, 1'b0);

        // R2 then R3: back-to-back lower/upper pair
        drive(2'b01, 1'b1, 1'b0, 12'h050, 32'h0000AAAA);
        expect_out(2, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b0);
        drive(2'b01, 1'b1, 1'b0, 12'h052, 32'h00007777);
        expect_out(3, 1'b1, 1'b0, 12'h050, 32'h7777AAAA, 1'b0, 32'h0, 1'b0);

        // R4 then R5: back-to-back lower/upper read of the new word
        drive(2'b01, 1'b0, 1'b1, 12'h050, 32'h0);
        expect_out(4, 1'b0, 1'b1, 12'h050, 32'h0, 1'b1, 32'h0000AAAA, 1'b0);
        drive(2'b01, 1'b0, 1'b1, 12'h052, 32'h0);
        expect_out(5, 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 32'h00007777, 1'b0);

        idle();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule